// File: doc/BRIEF.md
# Predicated Execute Stage with Per-Instruction Flag and Writeback Control

This block is the execute stage of a small 32-bit core whose instructions work memory-to-memory on a 512-word local RAM. Each instruction has two address fields. The destination field names a word that is both the first operand and the place the result goes. The source field names the second operand, or supplies it directly as an immediate. The stage receives the decoded fields and both operand words, already read from the RAM, in the same cycle. It returns the result word, a write enable and write address for the RAM port, and the zero and carry flags that it holds.

Flag and write behaviour is chosen by each instruction rather than by its opcode. Every instruction carries these controls:
- a 4-bit predicate evaluated against the current flags, which can cancel the instruction;
- a select for updating the zero flag;
- a select for updating the carry flag;
- a select for writing the result back;
- an immediate select.

Two opcodes reach a shared memory outside the core. While such an access waits for its completion strobe, the stage stalls and holds everything still. Writes and flag updates land on the clock edge that ends the execute cycle.

Top module: `exec_stage`

## Requirements
- R1: The write address equals the destination field. The destination word is the first operand (d), and the source operand (s) is the second.
- R2: Opcode encodings (6 bits):
  - 0x00 ADD: d+s
  - 0x01 SUB: d-s
  - 0x02 AND
  - 0x03 OR
  - 0x04 XOR
  - 0x05 MOV: s
  - 0x08 SHL
  - 0x09 SHR (logical)
  - 0x0A SAR (arithmetic)
  - 0x0B ROL
  - 0x0C ROR
  - 0x0D REV: bit-reversed d, then shifted right logically by the amount
  - 0x10 shared read: result is the shared read data
  - 0x11 shared write: result is d
  - Any other code passes d through.
- R3: When the immediate select is 1, s is the 9-bit source field zero-extended to 32 bits. When it is 0, s is the source RAM word.
- R4: The 4-bit predicate passes when bit index {C,Z} (C is the high bit) of the predicate is 1. So 0000 never passes and 1111 always passes.
- R5: A valid instruction whose predicate fails produces no write, changes no flag and makes no shared-memory request.
- R6: For an instruction that completes, the zero-flag select, the carry-flag select and the write select each act alone. A cleared select leaves its flag or the RAM word untouched.
- R7: Z becomes 1 exactly when the 32-bit result is zero. For ADD, C is the carry out. For SUB, C is the borrow, which is 1 when d < s unsigned.
- R8: Shifts and rotates take their amount from s[4:0]. C is the last bit shifted or rotated out: d[32-n] for SHL, ROL and REV, and d[n-1] for SHR, SAR and ROR. C is 0 when n is 0.
- R9: A passing shared-memory instruction raises its request. Until the done input is 1, busy stays 1, the write enable stays 0 and the flags hold. In the cycle with done at 1, the instruction completes. The request's write strobe is 1 only for opcode 0x11. The request carries s as the address and d as the write data.
- R10: Reset clears both flags and leaves the write enable, request and busy low.
- R11: AND, OR, XOR, MOV, the shared-memory opcodes and undefined opcodes set C to 0 when the carry select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 6 | Operation select |
| pred | input | 4 | Predicate truth table over {C,Z} |
| upd_z | input | 1 | Update zero flag on completion |
| upd_c | input | 1 | Update carry flag on completion |
| keep_res | input | 1 | Write result to destination on completion |
| use_imm | input | 1 | Source field is the operand |
| dst_field | input | 9 | Destination address |
| src_field | input | 9 | Source address or immediate |
| dst_val | input | 32 | Destination word from RAM |
| src_val | input | 32 | Source word from RAM |
| shm_done | input | 1 | Shared-memory access complete |
| shm_rdata | input | 32 | Shared-memory read data |
| result | output | 32 | Computed result |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 9 | RAM write address |
| shm_req | output | 1 | Shared-memory request |
| shm_we | output | 1 | Request is a write |
| shm_addr | output | 32 | Shared-memory address (s) |
| shm_wdata | output | 32 | Shared-memory write data (d) |
| busy | output | 1 | Stage stalled on shared memory |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Shift amounts 0, 1 and 31. A wrong carry tap gives a flipped carry at those edges, or a stale bit at amount 0.
- SUB with equal operands and with d < s. A missing borrow inversion clears C when it should be set.
- All sixteen predicate codes against every flag state. A swapped {C,Z} index shows up as writes from cancelled instructions.
- A multi-cycle shared-memory stall. A premature commit appears as an early write enable or a flag update before the done cycle.

Random mixes, including undefined opcodes and immediates at the 9-bit maximum, are compared cycle by cycle against a behavioural model.

// File: rtl/exec_pkg.sv
package exec_pkg;

    localparam int unsigned XW   = 32;
    localparam int unsigned AW   = 9;
    localparam int unsigned OPW  = 6;
    localparam int unsigned PW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 6'h00,
        OP_SUB  = 6'h01,
        OP_AND  = 6'h02,
        OP_OR   = 6'h03,
        OP_XOR  = 6'h04,
        OP_MOV  = 6'h05,
        OP_SHL  = 6'h08,
        OP_SHR  = 6'h09,
        OP_SAR  = 6'h0A,
        OP_ROL  = 6'h0B,
        OP_ROR  = 6'h0C,
        OP_REV  = 6'h0D,
        OP_SHRD = 6'h10,
        OP_SHWR = 6'h11
    } op_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  pre_rev;
        logic  post_rev;
        fill_e fill;
    } shctl_t;

    typedef struct packed {
        logic [PW-1:0] pred;
        logic          wz;
        logic          wc;
        logic          wr;
        logic          imm;
    } ctl_t;

    function automatic logic is_shift(input logic [OPW-1:0] op);
        return (op >= OP_SHL) && (op <= OP_REV);
    endfunction

    function automatic logic is_shared(input logic [OPW-1:0] op);
        return (op == OP_SHRD) || (op == OP_SHWR);
    endfunction

    function automatic logic is_arith(input logic [OPW-1:0] op);
        return op <= OP_XOR;
    endfunction

    function automatic shctl_t shift_ctl(input logic [OPW-1:0] op);
        shctl_t c;
        c = '{pre_rev: 1'b0, post_rev: 1'b0, fill: FILL_ZERO};
        case (op)
            OP_SHL: c = '{pre_rev: 1'b1, post_rev: 1'b1, fill: FILL_ZERO};
            OP_SAR: c = '{pre_rev: 1'b0, post_rev: 1'b0, fill: FILL_SIGN};
            OP_ROL: c = '{pre_rev: 1'b1, post_rev: 1'b1, fill: FILL_WRAP};
            OP_ROR: c = '{pre_rev: 1'b0, post_rev: 1'b0, fill: FILL_WRAP};
            OP_REV: c = '{pre_rev: 1'b1, post_rev: 1'b0, fill: FILL_ZERO};
            default: c = '{pre_rev: 1'b0, post_rev: 1'b0, fill: FILL_ZERO};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pred_unit.sv
module pred_unit
    import exec_pkg::*;
#(
    parameter int unsigned PRED_W = PW
) (
    input  logic [PRED_W-1:0] pred,
    input  logic              cur_z,
    input  logic              cur_c,
    output logic              pass
);
    localparam int unsigned IDX_W = $clog2(PRED_W);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx  = {cur_c, cur_z};
        pass = pred[idx];
    end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
    import exec_pkg::*;
#(
    parameter int unsigned W = XW
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   value,
    output logic           carry
);
    logic [W:0] sum;
    logic [W:0] diff;

    always_comb begin
        sum   = {1'b0, a} + {1'b0, b};
        diff  = {1'b0, a} - {1'b0, b};
        value = a;
        carry = 1'b0;
        case (op)
            OP_ADD: begin value = sum[W-1:0];  carry = sum[W];  end
            OP_SUB: begin value = diff[W-1:0]; carry = diff[W]; end
            OP_AND: value = a & b;
            OP_OR:  value = a | b;
            OP_XOR: value = a ^ b;
            default: begin value = a; carry = 1'b0; end
        endcase
    end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import exec_pkg::*;
#(
    parameter int unsigned W = XW
) (
    input  shctl_t               ctl,
    input  logic [W-1:0]         d,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         value,
    output logic                 carry
);
    localparam int unsigned EW = 2 * W + 1;

    logic [W-1:0]  d_rev;
    logic [W-1:0]  core;
    logic [W-1:0]  core_rev;
    logic [W-1:0]  pre;
    logic [W-1:0]  hi;
    logic [EW-1:0] ext;
    logic [EW-1:0] shifted;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign d_rev[i]    = d[W-1-i];
        assign core_rev[i] = core[W-1-i];
    end

    always_comb begin
        pre = ctl.pre_rev ? d_rev : d;
        case (ctl.fill)
            FILL_SIGN: hi = {W{pre[W-1]}};
            FILL_WRAP: hi = pre;
            default:   hi = '0;
        endcase
        ext     = {hi, pre, 1'b0};
        shifted = ext >> amt;
        core    = shifted[W:1];
        carry   = shifted[0];
        value   = ctl.post_rev ? core_rev : core;
    end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int unsigned DATA_W = XW,
    parameter int unsigned ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPW-1:0]    op_code,
    input  logic [PW-1:0]     pred,
    input  logic              upd_z,
    input  logic              upd_c,
    input  logic              keep_res,
    input  logic              use_imm,
    input  logic [ADDR_W-1:0] dst_field,
    input  logic [ADDR_W-1:0] src_field,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic              shm_done,
    input  logic [DATA_W-1:0] shm_rdata,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              shm_req,
    output logic              shm_we,
    output logic [DATA_W-1:0] shm_addr,
    output logic [DATA_W-1:0] shm_wdata,
    output logic              busy,
    output logic              flag_z,
    output logic              flag_c
);
    localparam int unsigned SW = $clog2(DATA_W);

    ctl_t              ctl;
    logic              pass;
    logic              commit;
    logic [DATA_W-1:0] opnd_s;
    logic [DATA_W-1:0] au_val;
    logic              au_c;
    logic [DATA_W-1:0] sh_val;
    logic              sh_c;
    logic              res_c;
    logic              z_q;
    logic              c_q;

    assign ctl = '{pred: pred, wz: upd_z, wc: upd_c, wr: keep_res, imm: use_imm};

    always_comb begin
        opnd_s = ctl.imm ? DATA_W'(src_field) : src_val;
    end

    pred_unit #(.PRED_W(PW)) u_pred (
        .pred  (ctl.pred),
        .cur_z (z_q),
        .cur_c (c_q),
        .pass  (pass)
    );

    arith_unit #(.W(DATA_W)) u_arith (
        .op    (op_code),
        .a     (dst_val),
        .b     (opnd_s),
        .value (au_val),
        .carry (au_c)
    );

    funnel_shifter #(.W(DATA_W)) u_shift (
        .ctl   (shift_ctl(op_code)),
        .d     (dst_val),
        .amt   (opnd_s[SW-1:0]),
        .value (sh_val),
        .carry (sh_c)
    );

    always_comb begin
        if (is_arith(op_code)) begin
            result = au_val;
            res_c  = au_c;
        end else if (is_shift(op_code)) begin
            result = sh_val;
            res_c  = sh_c;
        end else begin
            res_c = 1'b0;
            case (op_code)
                OP_MOV:  result = opnd_s;
                OP_SHRD: result = shm_rdata;
                default: result = dst_val;
            endcase
        end
    end

    always_comb begin
        shm_req   = in_valid && pass && is_shared(op_code);
        shm_we    = shm_req && (op_code == OP_SHWR);
        shm_addr  = opnd_s;
        shm_wdata = dst_val;
        busy      = shm_req && !shm_done;
        commit    = in_valid && pass && !busy;
        wr_en     = commit && ctl.wr;
        wr_addr   = dst_field;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (commit) begin
            if (ctl.wz) z_q <= (result == '0);
            if (ctl.wc) c_q <= res_c;
        end
    end

    assign flag_z = z_q;
    assign flag_c = c_q;
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
    import exec_pkg::*;
#(
    parameter int unsigned DATA_W = XW
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [PW-1:0]     pred,
    input logic              upd_z,
    input logic              upd_c,
    input logic              keep_res,
    input logic              wr_en,
    input logic              shm_req,
    input logic              busy,
    input logic [DATA_W-1:0] result,
    input logic              flag_z,
    input logic              flag_c
);
    assert_never_pred_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred == 4'h0) |-> (!wr_en && !shm_req));

    assert_cancel_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pred[{flag_c, flag_z}]) |=> (flag_z == $past(flag_z) && flag_c == $past(flag_c)));

    assert_cancel_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !pred[{flag_c, flag_z}]) |-> (!wr_en && !shm_req));

    assert_no_zupd_R6: assert property (@(posedge clk) disable iff (rst)
        (!upd_z) |=> (flag_z == $past(flag_z)));

    assert_no_cupd_R6: assert property (@(posedge clk) disable iff (rst)
        (!upd_c) |=> (flag_c == $past(flag_c)));

    assert_no_wr_R6: assert property (@(posedge clk) disable iff (rst)
        (!keep_res) |-> !wr_en);

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && upd_z && !busy && pred[{flag_c, flag_z}]) |=> (flag_z == ($past(result) == '0)));

    assert_stall_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!wr_en && shm_req));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (flag_z == $past(flag_z) && flag_c == $past(flag_c)));
endmodule

bind exec_stage exec_stage_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .pred     (pred),
    .upd_z    (upd_z),
    .upd_c    (upd_c),
    .keep_res (keep_res),
    .wr_en    (wr_en),
    .shm_req  (shm_req),
    .busy     (busy),
    .result   (result),
    .flag_z   (flag_z),
    .flag_c   (flag_c)
);

// File: tb/exec_stage_tb_top.sv
module exec_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  op_code;
    logic [3:0]  pred;
    logic        upd_z, upd_c, keep_res, use_imm;
    logic [8:0]  dst_field, src_field;
    logic [31:0] dst_val, src_val;
    logic        shm_done;
    logic [31:0] shm_rdata;
    logic [31:0] result;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic        shm_req, shm_we;
    logic [31:0] shm_addr, shm_wdata;
    logic        busy, flag_z, flag_c;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit mz = 0, mc = 0;

    always #5 clk = ~clk;

    exec_stage dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .pred(pred),
        .upd_z(upd_z), .upd_c(upd_c), .keep_res(keep_res), .use_imm(use_imm),
        .dst_field(dst_field), .src_field(src_field), .dst_val(dst_val), .src_val(src_val),
        .shm_done(shm_done), .shm_rdata(shm_rdata), .result(result), .wr_en(wr_en),
        .wr_addr(wr_addr), .shm_req(shm_req), .shm_we(shm_we), .shm_addr(shm_addr),
        .shm_wdata(shm_wdata), .busy(busy), .flag_z(flag_z), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: bit-serial shifting, one position at a time.
    task automatic model(input logic [5:0] op, input logic [31:0] d, input logic [31:0] s,
                         input logic [31:0] rd, output logic [31:0] r, output logic c);
        logic [32:0] w;
        int n;
        n = s[4:0];
        c = 1'b0;
        r = d;
        case (op)
            6'h00: begin w = {1'b0, d} + {1'b0, s}; r = w[31:0]; c = w[32]; end
            6'h01: begin r = d - s; c = (d < s); end
            6'h02: r = d & s;
            6'h03: r = d | s;
            6'h04: r = d ^ s;
            6'h05: r = s;
            6'h08: for (int k = 0; k < n; k++) begin c = r[31]; r = r << 1; end
            6'h09: for (int k = 0; k < n; k++) begin c = r[0]; r = r >> 1; end
            6'h0A: for (int k = 0; k < n; k++) begin c = r[0]; r = {r[31], r[31:1]}; end
            6'h0B: for (int k = 0; k < n; k++) begin c = r[31]; r = {r[30:0], r[31]}; end
            6'h0C: for (int k = 0; k < n; k++) begin c = r[0]; r = {r[0], r[31:1]}; end
            6'h0D: begin
                for (int k = 0; k < 32; k++) r[k] = d[31-k];
                for (int k = 0; k < n; k++) begin c = r[0]; r = r >> 1; end
            end
            6'h10: r = rd;
            6'h11: r = d;
            default: r = d;
        endcase
    endtask

    task automatic step(input string req, input logic v, input logic [5:0] op, input logic [3:0] p,
                        input logic wz, input logic wc, input logic wr, input logic im,
                        input logic [8:0] df, input logic [8:0] sf, input logic [31:0] dv,
                        input logic [31:0] sv, input logic done, input logic [31:0] rd);
        logic [31:0] s, er;
        logic ec, ok, ereq, ebusy, commit;
        @(negedge clk);
        in_valid = v; op_code = op; pred = p; upd_z = wz; upd_c = wc; keep_res = wr;
        use_imm = im; dst_field = df; src_field = sf; dst_val = dv; src_val = sv;
        shm_done = done; shm_rdata = rd;
        #1;
        s = im ? {23'b0, sf} : sv;
        model(op, dv, s, rd, er, ec);
        ok     = p[{mc, mz}];
        ereq   = v && ok && (op == 6'h10 || op == 6'h11);
        ebusy  = ereq && !done;
        commit = v && ok && !ebusy;
        if (v) chk(req, "result", result, er);
        chk(req, "wr_en", {31'b0, wr_en}, {31'b0, commit && wr});
        if (wr_en) chk("R1", "wr_addr", {23'b0, wr_addr}, {23'b0, df});
        chk(req, "shm_req", {31'b0, shm_req}, {31'b0, ereq});
        chk(req, "busy", {31'b0, busy}, {31'b0, ebusy});
        if (ereq) begin
            chk("R9", "shm_we", {31'b0, shm_we}, {31'b0, op == 6'h11});
            chk("R9", "shm_addr", shm_addr, s);
            chk("R9", "shm_wdata", shm_wdata, dv);
        end
        @(posedge clk);
        if (commit && wz) mz = (er == 32'h0);
        if (commit && wc) mc = ec;
        #1;
        chk(req, "flag_z", {31'b0, flag_z}, {31'b0, mz});
        chk(req, "flag_c", {31'b0, flag_c}, {31'b0, mc});
    endtask

    // Plain ALU op, always predicate, all selects on
    task automatic alu(input string req, input logic [5:0] op, input logic [31:0] d, input logic [31:0] s);
        step(req, 1, op, 4'hF, 1, 1, 1, 0, 9'd7, 9'd3, d, s, 1'b0, 32'h0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1; in_valid = 0; op_code = 0; pred = 0; upd_z = 0; upd_c = 0; keep_res = 0;
        use_imm = 0; dst_field = 0; src_field = 0; dst_val = 0; src_val = 0;
        shm_done = 0; shm_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "flag_z", {31'b0, flag_z}, 32'h0);
        chk("R10", "flag_c", {31'b0, flag_c}, 32'h0);
        chk("R10", "wr_en", {31'b0, wr_en}, 32'h0);
        chk("R10", "busy", {31'b0, busy}, 32'h0);
        rst = 0;

        // R7: arithmetic carry and borrow
        alu("R7", 6'h00, 32'hFFFF_FFFF, 32'h1);
        alu("R7", 6'h00, 32'h1234_0000, 32'h0000_5678);
        alu("R7", 6'h01, 32'h5, 32'h5);
        alu("R7", 6'h01, 32'h3, 32'h9);
        // R11: logic ops clear carry
        alu("R11", 6'h02, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        alu("R11", 6'h04, 32'hAAAA_5555, 32'h0000_FFFF);
        alu("R11", 6'h05, 32'h1, 32'h8000_0000);
        alu("R11", 6'h3F, 32'hDEAD_BEEF, 32'h1);
        // R8: shift edges 0, 1, 31 for every shift type
        for (int op = 8; op <= 13; op++) begin
            alu("R8", 6'(op), 32'h8000_0001, 32'd1);
            alu("R8", 6'(op), 32'hC000_0003, 32'd31);
            alu("R8", 6'(op), 32'hA5A5_0F0F, 32'd0);
            alu("R8", 6'(op), 32'h9ABC_DEF1, 32'd13);
        end
        // R3: immediate at 9-bit maximum
        step("R3", 1, 6'h00, 4'hF, 1, 1, 1, 1, 9'd5, 9'h1FF, 32'h10, 32'hFFFF_0000, 0, 0);
        step("R3", 1, 6'h05, 4'hF, 1, 1, 1, 1, 9'd5, 9'h0A5, 32'h10, 32'h7777_7777, 0, 0);
        // R4/R5: every predicate under every flag state
        for (int f = 0; f < 4; f++) begin
            // set flags: Z from zero result, C from add carry
            alu("R7", 6'h00, (f[1] ? 32'hFFFF_FFFF : 32'h0), (f[1] ? 32'h1 : (f[0] ? 32'h0 : 32'h1)));
            if (f == 2) alu("R7", 6'h00, 32'hFFFF_FFFF, 32'h2);
            for (int p = 0; p < 16; p++)
                step("R4", 1, 6'h09, 4'(p), 0, 0, 1, 0, 9'd40, 9'd2, 32'h0, 32'h0, 0, 0);
            step("R5", 1, 6'h00, 4'h0, 1, 1, 1, 0, 9'd9, 9'd1, 32'h1, 32'h2, 0, 0);
        end
        // R6: individual selects
        step("R6", 1, 6'h01, 4'hF, 0, 1, 1, 0, 9'd11, 9'd0, 32'h1, 32'h2, 0, 0);
        step("R6", 1, 6'h01, 4'hF, 1, 0, 0, 0, 9'd12, 9'd0, 32'h2, 32'h2, 0, 0);
        step("R6", 1, 6'h00, 4'hF, 0, 0, 0, 0, 9'd13, 9'd0, 32'hFFFF_FFFF, 32'h1, 0, 0);
        // R9: shared read stalling three cycles
        for (int k = 0; k < 3; k++)
            step("R9", 1, 6'h10, 4'hF, 1, 1, 1, 0, 9'd20, 9'd1, 32'h55, 32'h1000, 0, 32'h0);
        step("R9", 1, 6'h10, 4'hF, 1, 1, 1, 0, 9'd20, 9'd1, 32'h55, 32'h1000, 1, 32'h0);
        step("R9", 1, 6'h11, 4'hF, 1, 1, 0, 1, 9'd21, 9'h44, 32'hCAFE_0001, 32'h0, 0, 32'h0);
        step("R9", 1, 6'h11, 4'hF, 1, 1, 0, 1, 9'd21, 9'h44, 32'hCAFE_0001, 32'h0, 1, 32'h0);
        // R9/R5: shared op cancelled by predicate makes no request
        step("R5", 1, 6'h10, 4'h0, 1, 1, 1, 0, 9'd22, 9'd1, 32'h1, 32'h2, 0, 32'h9);
        // R2/R1: random mix
        for (int k = 0; k < 600; k++) begin
            logic [5:0] op;
            op = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 18);
            step("R2", 1'($urandom % 8 != 0), op, 4'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 9'($urandom), 9'($urandom),
                 ($urandom % 5 == 0) ? 32'h0 : $urandom, $urandom,
                 1'($urandom % 3 != 0), $urandom);
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule